// File: doc/BRIEF.md
# PCI Single-Dword Write Target

This block is a reduced PCI target that accepts only 32-bit write transactions aimed at one of two address windows, one in I/O space and one in memory space. It watches the shared bus (cycle frame, initiator ready, command/byte-enable lanes and the multiplexed address/data lines). It compares the command and the upper address bits against two base values and answers with device-select, target-ready and stop. Each of these three has a level output and a separate drive enable, so the pad ring can build the tri-state buffers.

Response timing is fixed. The claim comes after a slow decode. Target-ready follows a set wait after the claim. Only the first data phase of any transaction is accepted: if the initiator signals a burst, the target takes the first dword and disconnects. Each accepted word appears on a local write port as a one-cycle strobe, with the dword address and the data.

The decode delay and the wait before the initiator-ready sample are parameters. Their defaults are 2 and 2, and all timing below uses those defaults.

Top module: `pci_wr_target`

## Requirements
- R1: An address phase is the first rising edge at which `bus_frame_n` is low while the target is idle. The command is read from `bus_cbe_n`: 4'b0011 is an I/O write and is compared against `io_window`; 4'b0111 is a memory write and is compared against `mem_window`. In both cases the compared bits are `bus_ad[31:8]`. On a mismatch, or for any other command, all three drive enables stay low and `wr_stb` stays low.
- R2: If a claimed address phase is sampled at edge A, device-select is driven low (`tgt_devsel_en`=1, `tgt_devsel_n`=0) from edge A+2. From that edge target-ready and stop are also driven, both high.
- R3: Initiator-ready is first sampled at edge A+4. If `bus_irdy_n` is low at that edge (edge T), target-ready is driven low from edge T.
- R4: If initiator-ready is high at edge A+4, the target keeps device-select low and target-ready high. It samples `bus_irdy_n` at every later edge and drives target-ready low from the first edge at which it is low.
- R5: At edge T+1 the dword on `bus_ad` is captured. For the following cycle `wr_stb` is 1, `wr_data` holds that dword and `wr_addr` holds bits 31:2 of the address-phase value. The byte-enable lanes during the data phase have no effect.
- R6: Target-ready is low for exactly one cycle. For a non-burst transfer (frame high at edge T), all three signals are driven high from edge T+1 for one cycle, and all drive enables are low from edge T+2.
- R7: If `bus_frame_n` is still low at edge T (a burst), stop is driven low from edge T, together with target-ready.
- R8: After a burst disconnect, stop and device-select stay low and target-ready stays high until an edge at which `bus_frame_n` is sampled high. For one cycle after that edge all three are driven high, and then all enables drop. A second dword presented after edge T+1 is not captured.
- R9: After any transaction, claimed or not, a new address phase is accepted only after an edge at which `bus_frame_n` and `bus_irdy_n` are both high. A frame-low cycle before that edge is never claimed.
- R10: While `rst_n` is low, all drive enables and `wr_stb` are low, including when reset arrives in the middle of a claimed transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_frame_n | input | 1 | Cycle frame from the initiator, active low |
| bus_irdy_n | input | 1 | Initiator ready, active low |
| bus_cbe_n | input | 4 | Command in the address phase, byte enables in data phases |
| bus_ad | input | 32 | Multiplexed address/data lines |
| io_window | input | 24 | Base of the I/O write window (address bits 31:8) |
| mem_window | input | 24 | Base of the memory write window (address bits 31:8) |
| tgt_devsel_n | output | 1 | Device-select level, active low |
| tgt_devsel_en | output | 1 | Drive enable for device-select |
| tgt_trdy_n | output | 1 | Target-ready level, active low |
| tgt_trdy_en | output | 1 | Drive enable for target-ready |
| tgt_stop_n | output | 1 | Stop level, active low |
| tgt_stop_en | output | 1 | Drive enable for stop |
| wr_stb | output | 1 | One-cycle local write strobe |
| wr_addr | output | 30 | Dword address of the captured write |
| wr_data | output | 32 | Captured write data |

## Verification
The bench follows every cycle of each transaction, so an off-by-one error in the decode delay or in the initiator-ready sample point is reported as a device-select or target-ready edge in the wrong cycle. Several cases target the decoder: commands crossed with windows, read and configuration commands, and addresses whose low bits are set. A crossed decoder claims a foreign window, and a design that keeps the low bits corrupts `wr_addr`. Bursts with different frame-release delays check that stop stays low for the whole disconnect and that the second dword never reaches `wr_data`. A directed sequence holds frame low, with matching addresses, while the bus is still busy after a transaction; a target that returns to idle too early claims one of those cycles.

// File: rtl/pci_wr_pkg.sv
package pci_wr_pkg;

  localparam logic [3:0] CMD_IO_WRITE  = 4'b0011;
  localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_CLAIM,
    ST_XFER,
    ST_STOPHOLD,
    ST_RELEASE,
    ST_WAITIDLE
  } tgt_state_e;

  typedef struct packed {
    logic devsel_en;
    logic devsel_n;
    logic trdy_en;
    logic trdy_n;
    logic stop_en;
    logic stop_n;
  } tgt_drive_t;

  function automatic logic is_io_write(input logic [3:0] cmd);
    return cmd == CMD_IO_WRITE;
  endfunction

  function automatic logic is_mem_write(input logic [3:0] cmd);
    return cmd == CMD_MEM_WRITE;
  endfunction

endpackage

// File: rtl/pci_wr_decode.sv
module pci_wr_decode #(
  parameter int BASE_W = 24
) (
  input  logic [3:0]        cmd,
  input  logic [BASE_W-1:0] addr_upper,
  input  logic [BASE_W-1:0] io_window,
  input  logic [BASE_W-1:0] mem_window,
  output logic              addr_hit
);
  import pci_wr_pkg::*;

  function automatic logic window_match(input logic [3:0] c,
                                        input logic [BASE_W-1:0] up,
                                        input logic [BASE_W-1:0] io_b,
                                        input logic [BASE_W-1:0] mem_b);
    logic io_ok;
    logic mem_ok;
    io_ok  = is_io_write(c)  && (up == io_b);
    mem_ok = is_mem_write(c) && (up == mem_b);
    return io_ok || mem_ok;
  endfunction

  always_comb addr_hit = window_match(cmd, addr_upper, io_window, mem_window);

endmodule

// File: rtl/pci_wr_fsm.sv
module pci_wr_fsm #(
  parameter int DECODE_CYC = 2,
  parameter int TRDY_WAIT  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_n,
  input  logic                   irdy_n,
  input  logic                   addr_hit,
  output pci_wr_pkg::tgt_state_e state,
  output logic                   burst,
  output logic                   addr_phase,
  output logic                   claim,
  output logic                   data_take
);
  import pci_wr_pkg::*;

  localparam int MAX_CYC = (DECODE_CYC > TRDY_WAIT) ? DECODE_CYC : TRDY_WAIT;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] DEC_LAST  = CNT_W'(DECODE_CYC);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(TRDY_WAIT);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  tgt_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             burst_q, burst_d;

  always_comb addr_phase = (state_q == ST_IDLE) && !frame_n;
  always_comb claim      = addr_phase && addr_hit;
  always_comb data_take  = (state_q == ST_XFER);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    burst_d = burst_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!frame_n) begin
          state_d = addr_hit ? ST_DECODE : ST_WAITIDLE;
          cnt_d   = CNT_ONE;
          burst_d = 1'b0;
        end
      end
      ST_DECODE: begin
        if (cnt_q == DEC_LAST) begin
          state_d = ST_CLAIM;
          cnt_d   = CNT_ONE;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      ST_CLAIM: begin
        if (cnt_q == WAIT_LAST) begin
          if (!irdy_n) begin
            state_d = ST_XFER;
            burst_d = !frame_n;
          end
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      ST_XFER: begin
        state_d = (burst_q && !frame_n) ? ST_STOPHOLD : ST_RELEASE;
      end
      ST_STOPHOLD: begin
        if (frame_n) state_d = ST_RELEASE;
      end
      ST_RELEASE: begin
        state_d = ST_WAITIDLE;
      end
      ST_WAITIDLE: begin
        if (frame_n && irdy_n) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      burst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      burst_q <= burst_d;
    end
  end

  assign state = state_q;
  assign burst = burst_q;

endmodule

// File: rtl/pci_wr_drive.sv
module pci_wr_drive (
  input  pci_wr_pkg::tgt_state_e state,
  input  logic                   burst,
  output pci_wr_pkg::tgt_drive_t drv
);
  import pci_wr_pkg::*;

  function automatic tgt_drive_t pattern(input logic en, input logic dev_n,
                                         input logic trdy_n, input logic stop_n);
    tgt_drive_t p;
    p.devsel_en = en;
    p.devsel_n  = dev_n;
    p.trdy_en   = en;
    p.trdy_n    = trdy_n;
    p.stop_en   = en;
    p.stop_n    = stop_n;
    return p;
  endfunction

  always_comb begin
    unique case (state)
      ST_CLAIM:    drv = pattern(1'b1, 1'b0, 1'b1, 1'b1);
      ST_XFER:     drv = pattern(1'b1, 1'b0, 1'b0, !burst);
      ST_STOPHOLD: drv = pattern(1'b1, 1'b0, 1'b1, 1'b0);
      ST_RELEASE:  drv = pattern(1'b1, 1'b1, 1'b1, 1'b1);
      default:     drv = pattern(1'b0, 1'b1, 1'b1, 1'b1);
    endcase
  end

endmodule

// File: rtl/pci_wr_latch.sv
module pci_wr_latch #(
  parameter int AD_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad,
  input  logic            addr_phase,
  input  logic            data_take,
  output logic            wr_stb,
  output logic [AD_W-3:0] wr_addr,
  output logic [AD_W-1:0] wr_data
);
  logic [AD_W-3:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_stb  <= 1'b0;
    end else begin
      wr_stb <= data_take;
      if (addr_phase) addr_q <= ad[AD_W-1:2];
      if (data_take) begin
        wr_addr <= addr_q;
        wr_data <= ad;
      end
    end
  end

endmodule

// File: rtl/pci_wr_target.sv
module pci_wr_target #(
  parameter int AD_W       = 32,
  parameter int BASE_W     = 24,
  parameter int DECODE_CYC = 2,
  parameter int TRDY_WAIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_frame_n,
  input  logic              bus_irdy_n,
  input  logic [3:0]        bus_cbe_n,
  input  logic [AD_W-1:0]   bus_ad,
  input  logic [BASE_W-1:0] io_window,
  input  logic [BASE_W-1:0] mem_window,
  output logic              tgt_devsel_n,
  output logic              tgt_devsel_en,
  output logic              tgt_trdy_n,
  output logic              tgt_trdy_en,
  output logic              tgt_stop_n,
  output logic              tgt_stop_en,
  output logic              wr_stb,
  output logic [AD_W-3:0]   wr_addr,
  output logic [AD_W-1:0]   wr_data
);
  import pci_wr_pkg::*;

  tgt_state_e state;
  tgt_drive_t drv;
  logic       burst;
  logic       addr_hit;
  logic       addr_phase;
  logic       claim;
  logic       data_take;

  pci_wr_decode #(.BASE_W(BASE_W)) u_decode (
    .cmd        (bus_cbe_n),
    .addr_upper (bus_ad[AD_W-1 -: BASE_W]),
    .io_window  (io_window),
    .mem_window (mem_window),
    .addr_hit   (addr_hit)
  );

  pci_wr_fsm #(.DECODE_CYC(DECODE_CYC), .TRDY_WAIT(TRDY_WAIT)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (bus_frame_n),
    .irdy_n     (bus_irdy_n),
    .addr_hit   (addr_hit),
    .state      (state),
    .burst      (burst),
    .addr_phase (addr_phase),
    .claim      (claim),
    .data_take  (data_take)
  );

  pci_wr_drive u_drive (
    .state (state),
    .burst (burst),
    .drv   (drv)
  );

  pci_wr_latch #(.AD_W(AD_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .ad         (bus_ad),
    .addr_phase (addr_phase),
    .data_take  (data_take),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );

  assign tgt_devsel_n  = drv.devsel_n;
  assign tgt_devsel_en = drv.devsel_en;
  assign tgt_trdy_n    = drv.trdy_n;
  assign tgt_trdy_en   = drv.trdy_en;
  assign tgt_stop_n    = drv.stop_n;
  assign tgt_stop_en   = drv.stop_en;

endmodule

// File: rtl/pci_wr_target_chk.sv
module pci_wr_target_chk #(
  parameter int DECODE_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic bus_frame_n,
  input logic bus_irdy_n,
  input logic tgt_devsel_n,
  input logic tgt_devsel_en,
  input logic tgt_trdy_n,
  input logic tgt_trdy_en,
  input logic tgt_stop_n,
  input logic tgt_stop_en,
  input logic wr_stb,
  input logic addr_phase,
  input logic addr_hit,
  input logic claim
);
  localparam logic [7:0] CLAIM_AGE = 8'(DECODE_CYC + 1);

  logic [7:0] since_claim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_claim <= '0;
    else if (claim) since_claim <= 8'd1;
    else if (since_claim != 8'd0 && since_claim != 8'hff) since_claim <= since_claim + 8'd1;
  end

  a_r1_unclaimed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !addr_hit) |=> !tgt_devsel_en);

  a_r2_devsel_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_devsel_en) |-> (since_claim == CLAIM_AGE) && !tgt_devsel_n);

  a_r3_trdy_needs_irdy: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_trdy_en && !tgt_trdy_n) |-> $past(!bus_irdy_n));

  a_r5_stb_after_trdy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(tgt_trdy_en && !tgt_trdy_n));

  a_r5_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r6_trdy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_trdy_en && !tgt_trdy_n) |=> (tgt_trdy_en && tgt_trdy_n));

  a_r7_stop_with_trdy: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_stop_en && $fell(tgt_stop_n)) |-> (tgt_trdy_en && !tgt_trdy_n));

  a_r8_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_stop_en && !tgt_stop_n && !bus_frame_n) |=> (tgt_stop_en && !tgt_stop_n && !tgt_devsel_n));

endmodule

bind pci_wr_target pci_wr_target_chk #(.DECODE_CYC(DECODE_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_frame_n   (bus_frame_n),
  .bus_irdy_n    (bus_irdy_n),
  .tgt_devsel_n  (tgt_devsel_n),
  .tgt_devsel_en (tgt_devsel_en),
  .tgt_trdy_n    (tgt_trdy_n),
  .tgt_trdy_en   (tgt_trdy_en),
  .tgt_stop_n    (tgt_stop_n),
  .tgt_stop_en   (tgt_stop_en),
  .wr_stb        (wr_stb),
  .addr_phase    (addr_phase),
  .addr_hit      (addr_hit),
  .claim         (claim)
);

// File: tb/test_pci_wr_target.sv
module test_pci_wr_target;

  localparam logic [23:0] IO_BASE  = 24'h001234;
  localparam logic [23:0] MEM_BASE = 24'hA55A01;

  // {devsel_en, devsel_n, trdy_en, trdy_n, stop_en, stop_n, stb}
  localparam logic [6:0] E_NONE  = 7'b0101010;
  localparam logic [6:0] E_CLAIM = 7'b1011110;
  localparam logic [6:0] E_REL   = 7'b1111110;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic [31:0] data;
    logic        burst;
    logic [3:0]  d;
    logic [3:0]  e;
    logic        claim;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{4'b0111, 32'hA55A0140, 32'hDEADBEEF, 1'b0, 4'd0, 4'd0, 1'b1},
    '{4'b0011, 32'h0012340C, 32'h12345678, 1'b0, 4'd2, 4'd0, 1'b1},
    '{4'b0111, 32'hA55A01F8, 32'hCAFEF00D, 1'b0, 4'd6, 4'd0, 1'b1},
    '{4'b0111, 32'hA55A0100, 32'h0BADF00D, 1'b1, 4'd0, 4'd0, 1'b1},
    '{4'b0011, 32'h00123400, 32'h600DCAFE, 1'b1, 4'd3, 4'd2, 1'b1},
    '{4'b0111, 32'h00123410, 32'h11111111, 1'b0, 4'd0, 4'd0, 1'b0},
    '{4'b0011, 32'h00123510, 32'h22222222, 1'b0, 4'd1, 4'd0, 1'b0},
    '{4'b0110, 32'hA55A0140, 32'h33333333, 1'b0, 4'd0, 4'd0, 1'b0},
    '{4'b1011, 32'hA55A0140, 32'h44444444, 1'b0, 4'd0, 4'd0, 1'b0},
    '{4'b0111, 32'hA55A01FF, 32'h55555555, 1'b0, 4'd3, 4'd0, 1'b1},
    '{4'b0011, 32'hA55A0144, 32'h66666666, 1'b0, 4'd0, 4'd0, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        bus_frame_n;
  logic        bus_irdy_n;
  logic [3:0]  bus_cbe_n;
  logic [31:0] bus_ad;
  logic        tgt_devsel_n, tgt_devsel_en;
  logic        tgt_trdy_n, tgt_trdy_en;
  logic        tgt_stop_n, tgt_stop_en;
  logic        wr_stb;
  logic [29:0] wr_addr;
  logic [31:0] wr_data;

  int n_tests = 0;
  int n_fail  = 0;

  pci_wr_target i_pci_wr_target (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_frame_n   (bus_frame_n),
    .bus_irdy_n    (bus_irdy_n),
    .bus_cbe_n     (bus_cbe_n),
    .bus_ad        (bus_ad),
    .io_window     (IO_BASE),
    .mem_window    (MEM_BASE),
    .tgt_devsel_n  (tgt_devsel_n),
    .tgt_devsel_en (tgt_devsel_en),
    .tgt_trdy_n    (tgt_trdy_n),
    .tgt_trdy_en   (tgt_trdy_en),
    .tgt_stop_n    (tgt_stop_n),
    .tgt_stop_en   (tgt_stop_en),
    .wr_stb        (wr_stb),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [6:0] norm(input logic [6:0] v);
    logic [6:0] r;
    r = v;
    if (!r[6]) r[5] = 1'b1;
    if (!r[4]) r[3] = 1'b1;
    if (!r[2]) r[1] = 1'b1;
    return r;
  endfunction

  function automatic logic [6:0] e_xfer(input logic burst);
    return {5'b10101, !burst, 1'b0};
  endfunction

  function automatic logic [6:0] e_stophold(input logic stb);
    return {6'b101110, stb};
  endfunction

  task automatic check_bus(input string tag, input logic [6:0] exp,
                           input logic [29:0] ea, input logic [31:0] ed);
    logic [6:0] act;
    act = {tgt_devsel_en, tgt_devsel_n, tgt_trdy_en, tgt_trdy_n,
           tgt_stop_en, tgt_stop_n, wr_stb};
    n_tests++;
    if (norm(act) !== norm(exp)) begin
      n_fail++;
      $display("FAIL %s: bus outputs %b, expected %b", tag, act, exp);
    end else if (exp[0] && (wr_addr !== ea || wr_data !== ed)) begin
      n_fail++;
      $display("FAIL %s: write addr/data %h/%h, expected %h/%h",
               tag, wr_addr, wr_data, ea, ed);
    end
  endtask

  task automatic bus_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_frame_n = 1'b1;
      bus_irdy_n  = 1'b1;
      bus_cbe_n   = 4'hF;
    end
  endtask

  // Drives one transaction and checks every cycle after the address edge A.
  task automatic run_txn(input vec_t v);
    int t;
    int last;
    logic [6:0] ex;
    string tag;
    t    = (int'(v.d) + 1 > 4) ? int'(v.d) + 1 : 4;
    last = !v.claim ? 8 : (v.burst ? t + 4 + int'(v.e) : t + 3);
    @(negedge clk);
    bus_frame_n = 1'b0;
    bus_irdy_n  = 1'b1;
    bus_ad      = v.addr;
    bus_cbe_n   = v.cmd;
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      if (!v.claim) begin
        ex = E_NONE; tag = "R1";
      end else if (k < 2) begin
        ex = E_NONE; tag = "R2";
      end else if (k < t) begin
        ex = E_CLAIM; tag = (k >= 4) ? "R4" : "R2";
      end else if (k == t) begin
        ex = e_xfer(v.burst); tag = v.burst ? "R7" : "R3";
      end else if (!v.burst) begin
        ex = (k == t + 1) ? {6'b111111, 1'b1} : E_NONE;
        tag = (k == t + 1) ? "R5" : "R6";
      end else if (k <= t + 1 + int'(v.e)) begin
        ex = e_stophold(k == t + 1); tag = (k == t + 1) ? "R5" : "R8";
      end else begin
        ex = (k == t + 2 + int'(v.e)) ? E_REL : E_NONE; tag = "R8";
      end
      check_bus(tag, ex, v.addr[31:2], v.data);
      if (k == 0) begin
        bus_ad    = v.data;
        bus_cbe_n = 4'h5;
      end
      if (k == int'(v.d)) begin
        bus_irdy_n = 1'b0;
        if (!v.burst) bus_frame_n = 1'b1;
      end
      if (v.burst && k == t + 1) bus_ad = ~v.data;
      if (v.burst && k == t + 1 + int'(v.e)) bus_frame_n = 1'b1;
      if (v.burst && k == t + 2 + int'(v.e)) bus_irdy_n = 1'b1;
      if (!v.burst && v.claim && k == t + 1) bus_irdy_n = 1'b1;
      if (!v.claim && k == 6) bus_irdy_n = 1'b1;
    end
    bus_idle(3);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    bus_frame_n = 1'b1;
    bus_irdy_n  = 1'b1;
    bus_cbe_n   = 4'hF;
    bus_ad      = '0;
    repeat (3) @(negedge clk);
    check_bus("R10", E_NONE, '0, '0);
    rst_n = 1'b1;
    bus_idle(2);

    for (int i = 0; i < NV; i++) run_txn(VECS[i]);

    // R9: busy bus after an unclaimed address phase with matching addresses later
    @(negedge clk);
    bus_frame_n = 1'b0; bus_irdy_n = 1'b1;
    bus_ad = 32'h77000000; bus_cbe_n = 4'b0111;
    @(negedge clk);
    bus_irdy_n = 1'b0; bus_ad = 32'hA55A0140; bus_cbe_n = 4'b0111;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check_bus("R9", E_NONE, '0, '0);
    end
    bus_frame_n = 1'b1;
    @(negedge clk);
    check_bus("R9", E_NONE, '0, '0);
    bus_frame_n = 1'b0; bus_ad = 32'h0012340C; bus_cbe_n = 4'b0011;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check_bus("R9", E_NONE, '0, '0);
    end
    bus_idle(3);
    run_txn(VECS[0]);

    // R10: reset while the target holds device-select
    @(negedge clk);
    bus_frame_n = 1'b0; bus_ad = 32'hA55A0180; bus_cbe_n = 4'b0111;
    @(negedge clk);
    bus_ad = 32'h0; bus_cbe_n = 4'h0;
    repeat (2) @(negedge clk);
    check_bus("R2", E_CLAIM, '0, '0);
    rst_n = 1'b0;
    bus_frame_n = 1'b1;
    #1;
    check_bus("R10", E_NONE, '0, '0);
    bus_idle(2);
    rst_n = 1'b1;
    bus_idle(2);
    run_txn(VECS[1]);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule